// File: doc/BRIEF.md
# ULPI Link-Side Bus Controller

This block sits at the link end of an 8-bit ULPI bus. The PHY supplies the bus clock and always controls who owns the data lines. While the PHY leaves the direction line low, the block drives the data lines and the stop line. It samples the direction line, the next line and the incoming data on every rising clock edge. A user-side command port starts one of three operations: sending a transmit packet, writing a PHY register, or reading a PHY register. A completion pulse or an abort pulse ends each command.

Whenever the PHY drives the bus, every valid byte goes out on a simple valid/data stream. A flag on that stream tells packet data apart from RX CMD status bytes. The block ignores the data lines during each turnaround cycle. It aborts a command that the PHY interrupts by taking the bus. While the clock is stopped in low-power mode, it passes the line state and the interrupt indication straight through as asynchronous outputs.

Top module: `ulpi_link_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `bus_out` is 8'h00, `bus_stp` is 0, and `done`, `abort` and `rx_valid` are 0.
- R2: With no command in progress, `bus_out` is 8'h00. `bus_oe` is high exactly when `phy_dir` is low.
- R3: An accepted command puts a command byte `{cmd_kind, cmd_addr}` on `bus_out`, with kind 2'b01 for transmit, 2'b10 for register write and 2'b11 for register read. Kind 2'b00 is never accepted. The byte stays on the bus until `phy_nxt` is sampled high.
- R4: For a register write, the cycle after the command byte is accepted carries `cmd_wdata`. Once that byte is accepted with `phy_nxt`, the next cycle has `bus_stp` high for exactly one cycle and `bus_out` at 8'h00. `done` pulses in the cycle after the stop.
- R5: For a transmit, payload bytes come from `tx_data`, and each byte advances only on `phy_nxt`. `tx_ready` is high in exactly the cycles in which `tx_data` and `tx_last` are taken. The byte taken with `tx_last` is followed by the same stop and `done` sequence as in R4.
- R6: For a register read, `bus_out` returns to 8'h00 once the command byte is accepted. The block then waits for `phy_dir` to rise. The cycle after the rise is turnaround. The cycle after that is captured into `rd_data` whatever `phy_nxt` is, and `done` pulses one cycle later.
- R7: When `phy_dir` rises together with `phy_nxt`, a receive starts and `rx_active` goes high until `phy_dir` falls. A byte sampled with the PHY owning the bus is reported on `rx_data` one cycle later, with `rx_is_cmd` = 0 if `phy_nxt` was high and 1 if it was low.
- R8: No `rx_valid` is produced for the sample taken in the first cycle after any change of `phy_dir`, or for register-read data.
- R9: If `phy_dir` rises while a command byte or data byte is waiting, or while a read is waiting for the PHY and `phy_nxt` rises with it, the block pulses `abort`, does not assert `bus_stp`, and returns to idle.
- R10: `cmd_ready` is high only when idle and `phy_dir` has been low in both the current and the previous sample. No command is taken while it is low.
- R11: While `phy_dir` is high, `lp_linestate` equals `bus_in[1:0]` and `lp_int` equals `bus_in[3]` with no clock involved. While `phy_dir` is low, both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock supplied by the PHY |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_kind | input | 2 | 01 transmit, 10 register write, 11 register read |
| cmd_addr | input | 6 | Register address, or the transmit command's low bits |
| cmd_wdata | input | 8 | Register write data |
| cmd_ready | output | 1 | Command taken this cycle when `cmd_valid` is high |
| tx_data | input | 8 | Transmit payload byte |
| tx_last | input | 1 | Marks the final payload byte |
| tx_ready | output | 1 | Payload byte taken this cycle |
| done | output | 1 | Command completed |
| abort | output | 1 | Command interrupted by the PHY, retry needed |
| rd_data | output | 8 | Last register read result |
| rx_valid | output | 1 | Received byte valid |
| rx_data | output | 8 | Received byte |
| rx_is_cmd | output | 1 | Received byte is an RX CMD |
| rx_active | output | 1 | Receive in progress |
| lp_linestate | output | 2 | Asynchronous line state in low-power mode |
| lp_int | output | 1 | Asynchronous interrupt indication in low-power mode |
| phy_dir | input | 1 | Bus direction from the PHY |
| phy_nxt | input | 1 | Throttle and receive indication from the PHY |
| bus_in | input | 8 | Data lines as seen from the link |
| bus_out | output | 8 | Data driven by the link |
| bus_oe | output | 1 | Output enable for `bus_out` |
| bus_stp | output | 1 | Stop line |

## Verification
A state machine stuck in the wrong state shows up on `bus_out` in the very next cycle. The symptoms are a command byte that is not held, a data byte that advances without `phy_nxt`, or a nonzero idle value. A stop that is early, late or doubled is visible on `bus_stp` one cycle after the final accept. A stale copy of the direction line shows up as a spurious `rx_valid` or a missing one right after a turnaround. It also holds `cmd_ready` high during the turnaround cycle. A corrupted captured read appears in `rd_data` in the same cycle as `done`.

// File: rtl/ulpi_link_ctrl.sv
module ulpi_link_ctrl #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_kind,
  input  logic [DW-3:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  output logic          cmd_ready,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_last,
  output logic          tx_ready,
  output logic          done,
  output logic          abort,
  output logic [DW-1:0] rd_data,
  output logic          rx_valid,
  output logic [DW-1:0] rx_data,
  output logic          rx_is_cmd,
  output logic          rx_active,
  output logic [1:0]    lp_linestate,
  output logic          lp_int,
  input  logic          phy_dir,
  input  logic          phy_nxt,
  input  logic [DW-1:0] bus_in,
  output logic [DW-1:0] bus_out,
  output logic          bus_oe,
  output logic          bus_stp
);
  localparam logic [1:0] K_TX = 2'b01;
  localparam logic [1:0] K_WR = 2'b10;
  localparam logic [1:0] K_RD = 2'b11;

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_DATA, S_STOP, S_RDWAIT, S_RDCAP} st_t;

  st_t        st;
  logic       dir_q;
  logic       last_q;
  logic [1:0] kind_q;
  logic [DW-1:0] wdata_q;

  assign bus_oe       = ~phy_dir;
  assign cmd_ready    = (st == S_IDLE) && !phy_dir && !dir_q;
  assign tx_ready     = !phy_dir && phy_nxt &&
                        (((st == S_CMD) && (kind_q == K_TX)) || ((st == S_DATA) && !last_q));
  assign lp_linestate = phy_dir ? bus_in[1:0] : 2'b00;
  assign lp_int       = phy_dir & bus_in[3];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      dir_q     <= 1'b1;
      last_q    <= 1'b0;
      kind_q    <= K_TX;
      wdata_q   <= '0;
      bus_out   <= '0;
      bus_stp   <= 1'b0;
      done      <= 1'b0;
      abort     <= 1'b0;
      rd_data   <= '0;
      rx_valid  <= 1'b0;
      rx_data   <= '0;
      rx_is_cmd <= 1'b0;
      rx_active <= 1'b0;
    end else begin
      dir_q    <= phy_dir;
      done     <= 1'b0;
      abort    <= 1'b0;
      bus_stp  <= 1'b0;
      rx_valid <= 1'b0;

      if (!phy_dir)
        rx_active <= 1'b0;
      else if (!dir_q && phy_nxt)
        rx_active <= 1'b1;

      if (phy_dir && dir_q && (st != S_RDCAP)) begin
        rx_valid  <= 1'b1;
        rx_data   <= bus_in;
        rx_is_cmd <= ~phy_nxt;
      end

      case (st)
        S_IDLE: begin
          bus_out <= '0;
          if (cmd_valid && cmd_ready && (cmd_kind != 2'b00)) begin
            kind_q  <= cmd_kind;
            wdata_q <= cmd_wdata;
            bus_out <= {cmd_kind, cmd_addr};
            st      <= S_CMD;
          end
        end
        S_CMD: begin
          if (phy_dir) begin
            abort   <= 1'b1;
            bus_out <= '0;
            st      <= S_IDLE;
          end else if (phy_nxt) begin
            case (kind_q)
              K_WR: begin
                bus_out <= wdata_q;
                last_q  <= 1'b1;
                st      <= S_DATA;
              end
              K_RD: begin
                bus_out <= '0;
                st      <= S_RDWAIT;
              end
              default: begin
                bus_out <= tx_data;
                last_q  <= tx_last;
                st      <= S_DATA;
              end
            endcase
          end
        end
        S_DATA: begin
          if (phy_dir) begin
            abort   <= 1'b1;
            bus_out <= '0;
            st      <= S_IDLE;
          end else if (phy_nxt) begin
            if (last_q) begin
              bus_out <= '0;
              bus_stp <= 1'b1;
              st      <= S_STOP;
            end else begin
              bus_out <= tx_data;
              last_q  <= tx_last;
            end
          end
        end
        S_STOP: begin
          done <= 1'b1;
          st   <= S_IDLE;
        end
        S_RDWAIT: begin
          if (phy_dir && !dir_q) begin
            if (phy_nxt) begin
              abort <= 1'b1;
              st    <= S_IDLE;
            end else begin
              st <= S_RDCAP;
            end
          end
        end
        S_RDCAP: begin
          rd_data <= bus_in;
          done    <= 1'b1;
          st      <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ulpi_link_ctrl_chk.sv
module ulpi_link_ctrl_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          phy_dir,
  input logic          phy_nxt,
  input logic          cmd_ready,
  input logic [DW-1:0] bus_out,
  input logic          bus_stp,
  input logic          done,
  input logic          abort,
  input logic          rx_valid
);
  a_r4_stop_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stp |-> ($past(phy_nxt) && !$past(phy_dir)));

  a_r4_stop_single: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stp |=> !bus_stp);

  a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (bus_out == '0));

  a_r9_abort_by_dir: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> ($past(phy_dir) && !bus_stp));

  a_r8_turnaround_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_dir != $past(phy_dir)) |=> !rx_valid);

  a_r6_single_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, abort}));

  a_r3_hold_until_nxt: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(bus_out) != '0) && !$past(phy_nxt) && !$past(phy_dir)) |-> (bus_out == $past(bus_out)));
endmodule

bind ulpi_link_ctrl ulpi_link_ctrl_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .phy_dir(phy_dir), .phy_nxt(phy_nxt),
  .cmd_ready(cmd_ready), .bus_out(bus_out), .bus_stp(bus_stp),
  .done(done), .abort(abort), .rx_valid(rx_valid)
);

// File: tb/sim_ulpi_link_ctrl.sv
module sim_ulpi_link_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_kind = 2'b00;
  logic [5:0] cmd_addr = '0;
  logic [7:0] cmd_wdata = '0;
  logic       cmd_ready;
  logic [7:0] tx_data = '0;
  logic       tx_last = 1'b0;
  logic       tx_ready, done, abort, rx_valid, rx_is_cmd, rx_active, lp_int, bus_oe, bus_stp;
  logic [7:0] rd_data, rx_data, bus_out;
  logic [1:0] lp_linestate;
  logic       phy_dir = 1'b0;
  logic       phy_nxt = 1'b0;
  logic [7:0] bus_in = '0;

  int n_chk = 0;
  int n_err = 0;
  bit ended = 1'b0;

  always #4 clk = ~clk;

  ulpi_link_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_ready(cmd_ready),
    .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready),
    .done(done), .abort(abort), .rd_data(rd_data), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_is_cmd(rx_is_cmd), .rx_active(rx_active),
    .lp_linestate(lp_linestate), .lp_int(lp_int), .phy_dir(phy_dir),
    .phy_nxt(phy_nxt), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
    .bus_stp(bus_stp)
  );

  function automatic logic [7:0] exp_cmd(input logic [1:0] k, input logic [5:0] a);
    return {k, a};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic nc();
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  task automatic issue(input logic [1:0] k, input logic [5:0] a, input logic [7:0] d);
    nc();
    cmd_valid = 1'b1; cmd_kind = k; cmd_addr = a; cmd_wdata = d;
    nc();
    cmd_valid = 1'b0;
    chk("R3 command byte", bus_out, exp_cmd(k, a));
  endtask

  task automatic do_write(input logic [5:0] a, input logic [7:0] d, input int s0, input int s1);
    issue(K_WR_B, a, d);
    phy_nxt = 1'b0;
    for (int i = 0; i < s0; i++) begin
      nc();
      chk("R3 command held", bus_out, exp_cmd(K_WR_B, a));
    end
    phy_nxt = 1'b1;
    nc();
    phy_nxt = 1'b0;
    chk("R4 write data", bus_out, d);
    chk("R4 no early stop", bus_stp, 0);
    for (int i = 0; i < s1; i++) begin
      nc();
      chk("R4 write data held", bus_out, d);
    end
    phy_nxt = 1'b1;
    nc();
    phy_nxt = 1'b0;
    chk("R4 stop", bus_stp, 1);
    chk("R4 bus zero at stop", bus_out, 0);
    nc();
    chk("R4 stop one cycle", bus_stp, 0);
    chk("R4 done", done, 1);
  endtask

  localparam logic [1:0] K_TX_B = 2'b01;
  localparam logic [1:0] K_WR_B = 2'b10;
  localparam logic [1:0] K_RD_B = 2'b11;

  task automatic do_tx(input logic [5:0] a, input int n);
    logic [7:0] pay [16];
    int k;
    bit first;
    for (int i = 0; i < 16; i++) pay[i] = 8'($urandom);
    issue(K_TX_B, a, 8'h00);
    k = 0;
    first = 1'b1;
    while (k <= n) begin
      chk("R5 byte on bus", bus_out, (k == 0) ? exp_cmd(K_TX_B, a) : pay[k-1]);
      tx_data = (k < n) ? pay[k] : 8'hEE;
      tx_last = (k == n - 1);
      phy_nxt = first ? 1'b0 : (($urandom % 3) != 0);
      first = 1'b0;
      #1;
      chk("R5 tx_ready", tx_ready, (phy_nxt && k < n) ? 1 : 0);
      nc();
      if (phy_nxt) k++;
    end
    phy_nxt = 1'b0;
    chk("R5 stop after last", bus_stp, 1);
    chk("R5 bus zero at stop", bus_out, 0);
    nc();
    chk("R5 done", done, 1);
    chk("R5 stop one cycle", bus_stp, 0);
  endtask

  task automatic do_read(input logic [5:0] a, input logic [7:0] v, input int s, input int w);
    issue(K_RD_B, a, 8'h00);
    for (int i = 0; i < s; i++) nc();
    chk("R3 read command held", bus_out, exp_cmd(K_RD_B, a));
    phy_nxt = 1'b1;
    nc();
    phy_nxt = 1'b0;
    chk("R6 bus zero after read cmd", bus_out, 0);
    for (int i = 0; i < w; i++) nc();
    chk("R6 no done before data", done, 0);
    phy_dir = 1'b1;
    bus_in = 8'($urandom);
    #1;
    chk("R2 tristate when PHY owns", bus_oe, 0);
    nc();
    bus_in = v;
    phy_nxt = 1'($urandom);
    nc();
    phy_nxt = 1'b0;
    chk("R6 read data", rd_data, v);
    chk("R6 done", done, 1);
    chk("R8 no rx for register data", rx_valid, 0);
    phy_dir = 1'b0;
    bus_in = 8'h00;
    #1;
    chk("R10 not ready in turnaround", cmd_ready, 0);
    nc();
    chk("R10 ready after turnaround", cmd_ready, 1);
    chk("R2 idle zero", bus_out, 0);
  endtask

  task automatic do_rx(input int n, input bit start_nxt);
    bit nx;
    logic [7:0] b;
    phy_dir = 1'b1;
    phy_nxt = start_nxt;
    bus_in = 8'($urandom);
    nc();
    chk("R8 no rx in turnaround", rx_valid, 0);
    chk("R7 rx_active on start", rx_active, start_nxt);
    for (int i = 0; i < n; i++) begin
      nx = (($urandom % 4) != 0);
      b = 8'($urandom);
      phy_nxt = nx;
      bus_in = b;
      nc();
      chk("R7 rx_valid", rx_valid, 1);
      chk("R7 rx_data", rx_data, b);
      chk("R7 rx_is_cmd", rx_is_cmd, !nx);
    end
    phy_dir = 1'b0;
    phy_nxt = 1'b0;
    bus_in = 8'h5A;
    nc();
    chk("R8 no rx after dir falls", rx_valid, 0);
    chk("R7 rx_active cleared", rx_active, 0);
    bus_in = 8'h00;
    nc();
  endtask

  initial begin
    #(8 * 200000);
    n_err++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) nc();
    chk("R1 reset bus", bus_out, 0);
    chk("R1 reset stop", bus_stp, 0);
    chk("R1 reset done", done, 0);
    chk("R1 reset rx", rx_valid, 0);
    chk("R2 drive enabled", bus_oe, 1);
    rst_n = 1'b1;
    nc();
    chk("R1 first cycle abort", abort, 0);
    nc();
    chk("R2 idle zero", bus_out, 0);

    cmd_valid = 1'b1; cmd_kind = 2'b00; cmd_addr = 6'h2A;
    nc();
    nc();
    cmd_valid = 1'b0;
    chk("R3 kind 00 ignored", bus_out, 0);

    do_write(6'h00, 8'hFF, 0, 0);
    do_write(6'h3F, 8'h00, 3, 2);
    for (int i = 0; i < 6; i++)
      do_write(6'($urandom), 8'($urandom), int'($urandom % 4), int'($urandom % 4));

    do_tx(6'h01, 1);
    for (int i = 0; i < 6; i++)
      do_tx(6'($urandom), 1 + int'($urandom % 10));

    do_read(6'h15, 8'hA5, 0, 0);
    for (int i = 0; i < 5; i++)
      do_read(6'($urandom), 8'($urandom), int'($urandom % 3), int'($urandom % 3));

    do_rx(6, 1'b1);
    do_rx(3, 1'b0);
    for (int i = 0; i < 3; i++) do_rx(2 + int'($urandom % 8), 1'($urandom));

    issue(K_WR_B, 6'h11, 8'h22);
    phy_dir = 1'b1;
    phy_nxt = 1'b1;
    nc();
    chk("R9 abort in command", abort, 1);
    chk("R9 no stop on abort", bus_stp, 0);
    chk("R9 no done on abort", done, 0);
    cmd_valid = 1'b1; cmd_kind = K_WR_B;
    #1;
    chk("R10 not ready while PHY owns", cmd_ready, 0);
    phy_nxt = 1'b0;
    nc();
    nc();
    cmd_valid = 1'b0;
    phy_dir = 1'b0;
    nc();
    nc();
    chk("R10 no command taken while PHY owned", bus_out, 0);

    issue(K_TX_B, 6'h03, 8'h00);
    tx_data = 8'h77; tx_last = 1'b0;
    phy_nxt = 1'b1;
    nc();
    phy_nxt = 1'b0;
    chk("R5 first payload", bus_out, 8'h77);
    phy_dir = 1'b1;
    nc();
    chk("R9 abort in data", abort, 1);
    chk("R9 no stop in data abort", bus_stp, 0);
    phy_dir = 1'b0;
    nc();
    nc();

    issue(K_RD_B, 6'h07, 8'h00);
    phy_nxt = 1'b1;
    nc();
    phy_dir = 1'b1;
    nc();
    chk("R9 read aborted by receive", abort, 1);
    chk("R7 receive started", rx_active, 1);
    phy_nxt = 1'b0;
    phy_dir = 1'b0;
    nc();
    nc();

    phy_dir = 1'b1;
    bus_in = 8'b0000_1010;
    #1;
    chk("R11 linestate", lp_linestate, 2'b10);
    chk("R11 interrupt", lp_int, 1);
    for (int i = 0; i < 4; i++) begin
      logic [7:0] b;
      b = 8'($urandom);
      bus_in = b;
      #2;
      chk("R11 linestate follows", lp_linestate, b[1:0]);
      chk("R11 interrupt follows", lp_int, b[3]);
    end
    phy_dir = 1'b0;
    bus_in = 8'hFF;
    #1;
    chk("R11 zero when link owns", {lp_int, lp_linestate}, 0);
    bus_in = 8'h00;
    nc();
    nc();
    chk("R2 idle zero at end", bus_out, 0);
    finish_run();
  end
endmodule